// File: doc/BRIEF.md
# Cartridge PRG Bank and Control Registers

This block sits on the CPU bus of a game cartridge and holds a small set of write-only control registers. From them it builds the upper PRG-ROM address lines for the $8000-$FFFF window. Two banking modes are available. In the first, a switchable 16 KiB bank sits in the lower half and a fixed bank sits in the upper half. In the second, one 32 KiB bank covers the whole window. A control bit picks the fixed bank used in 16 KiB mode: either the last bank (31), or bank 28 or 30, chosen by the lowest bank bit.

The same registers choose nametable mirroring. The block decodes the PRG-RAM window and the PRG-ROM chip enable. It also drives a bit-banged serial EEPROM port: firmware toggles data, clock and two chip-select lines through one register, and reads the returned data bit through another.

All registers clear to zero on reset. That selects 16 KiB mode, so the CPU fetches its reset vector from bank 31.

Top module: `cart_prg_ctrl`

## Requirements
- R1: After reset every register is zero: with CPU A14=1 the bank output is 7'h1F, mirroring is vertical, and all four serial outputs are low.
- R2: A register write is decided on the CPU address bits 15..8 alone. Page $50 is bank-low, $51 is bank-high, $52 is the serial port and $53 is mirroring. A write to any other page changes no output.
- R3: With bank-low bit 4 (mode) = 0 and CPU A14=0, PRG A18..A14 equal {bank-low bit 5, bits 3..0}.
- R4: With mode=0, CPU A14=1 and bank-low bit 6 = 0, PRG A18..A14 are all ones.
- R5: With mode=0, CPU A14=1 and bank-low bit 6 = 1, PRG A18..A16 are ones, A15 equals bank-low bit 0, and A14 is 0.
- R6: With mode=1, PRG A14 follows CPU A14 and PRG A18..A15 equal bank-low bits 3..0. Bank-low bits 5, 6 and 7 have no effect on the bank.
- R7: Bank-high bits 1..0 drive PRG A20..A19 in both modes. The bank output is ordered A20 down to A14.
- R8: With mode=0 the nametable A10 follows PPU A10 (vertical). With mode=1, mirroring-register bit 7 selects the source: 1 takes PPU A10 (vertical), 0 takes PPU A11 (horizontal).
- R9: In a serial-port write, bit 0 drives data out, bit 1 drives clock, bit 4 drives chip select 1 and bit 6 drives chip select 2. These outputs hold until the next serial-port write.
- R10: A read on page $55 asserts the read-hit flag and returns 8'b00000_x_00, where x is the inverted EEPROM input on bit 2. At any other time the read data is zero and the flag is low.
- R11: The PRG-RAM enable is high exactly for CPU $6000-$7FFF. The RAM address is CPU A10..A0, so a 2 KiB RAM repeats four times.
- R12: The PRG-ROM enable is high only on a CPU read with the address in $8000-$FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| ee_di | input | 1 | Serial EEPROM data input |
| prg_bank | output | 7 | PRG A20..A14 |
| prg_rom_ce | output | 1 | PRG-ROM enable |
| prg_ram_ce | output | 1 | PRG-RAM enable |
| prg_ram_addr | output | 11 | PRG-RAM address |
| ciram_a10 | output | 1 | Nametable RAM A10 |
| ee_do | output | 1 | Serial data out |
| ee_clk | output | 1 | Serial clock |
| ee_cs1 | output | 1 | Chip select 1 |
| ee_cs2 | output | 1 | Chip select 2 |
| cpu_rdata | output | 8 | Read data |
| cpu_rd_hit | output | 1 | Read of the serial input page |

## Verification
The mode bit steers two functions at once: the PRG bank mapping and the mirroring source. A single bank-low write can therefore change both on the same clock edge. The bench sets up this case by first loading the mirroring register with horizontal, with mode cleared. It then writes mode=1 in one access. At the next sampling point it checks that the bank output has moved to the 32 KiB mapping and that the nametable A10 has moved from PPU A10 to PPU A11, with no cycle between the two changes.

// File: rtl/cart_pkg.sv
package cart_pkg;

    localparam logic [7:0] PAGE_BLO = 8'h50;
    localparam logic [7:0] PAGE_BHI = 8'h51;
    localparam logic [7:0] PAGE_SER = 8'h52;
    localparam logic [7:0] PAGE_MIR = 8'h53;
    localparam logic [7:0] PAGE_RDS = 8'h55;

    typedef struct packed {
        logic       vid;
        logic       fix_sel;
        logic       hi_bit;
        logic       wide;
        logic [3:0] num;
    } bank_lo_t;

    typedef struct packed {
        logic cs2;
        logic cs1;
        logic sclk;
        logic sdo;
    } ser_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_BLO,
        SEL_BHI,
        SEL_SER,
        SEL_MIR
    } reg_sel_e;

    function automatic reg_sel_e page_sel(input logic [7:0] page);
        case (page)
            PAGE_BLO: return SEL_BLO;
            PAGE_BHI: return SEL_BHI;
            PAGE_SER: return SEL_SER;
            PAGE_MIR: return SEL_MIR;
            default:  return SEL_NONE;
        endcase
    endfunction

    // Five bank lines A18..A14 from the bank-low register and CPU A14
    function automatic logic [4:0] low_lines(input bank_lo_t r, input logic a14);
        if (r.wide)
            return {r.num, a14};
        else if (!a14)
            return {r.hi_bit, r.num};
        else if (r.fix_sel)
            return {3'b111, r.num[0], 1'b0};
        else
            return 5'b11111;
    endfunction

endpackage

// File: rtl/cart_regfile.sv
module cart_regfile
    import cart_pkg::*;
#(
    parameter int DW   = 8,
    parameter int HI_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [7:0]      page,
    input  logic [DW-1:0]   wdata,
    output bank_lo_t        bank_lo,
    output logic [HI_W-1:0] bank_hi,
    output ser_t            ser,
    output logic            mir_vert
);
    reg_sel_e sel;
    assign sel = wr ? page_sel(page) : SEL_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_lo  <= '0;
            bank_hi  <= '0;
            ser      <= '0;
            mir_vert <= 1'b0;
        end else begin
            case (sel)
                SEL_BLO: bank_lo <= bank_lo_t'(wdata[7:0]);
                SEL_BHI: bank_hi <= wdata[HI_W-1:0];
                SEL_SER: ser     <= '{cs2: wdata[6], cs1: wdata[4],
                                      sclk: wdata[1], sdo: wdata[0]};
                SEL_MIR: mir_vert <= wdata[7];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cart_prg_map.sv
module cart_prg_map
    import cart_pkg::*;
#(
    parameter int HI_W = 2,
    localparam int BW  = 5 + HI_W
) (
    input  bank_lo_t        bank_lo,
    input  logic [HI_W-1:0] bank_hi,
    input  logic            cpu_a14,
    output logic [BW-1:0]   prg_bank
);
    always_comb begin
        prg_bank = {bank_hi, low_lines(bank_lo, cpu_a14)};
    end
endmodule

// File: rtl/cart_mirror.sv
module cart_mirror (
    input  logic wide_mode,
    input  logic mir_vert,
    input  logic ppu_a10,
    input  logic ppu_a11,
    output logic ciram_a10
);
    logic use_vert;
    assign use_vert  = !wide_mode || mir_vert;
    assign ciram_a10 = use_vert ? ppu_a10 : ppu_a11;
endmodule

// File: rtl/cart_prg_ctrl.sv
module cart_prg_ctrl
    import cart_pkg::*;
#(
    parameter int RAM_AW = 11,
    parameter int HI_W   = 2,
    localparam int BW    = 5 + HI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic              ppu_a10,
    input  logic              ppu_a11,
    input  logic              ee_di,
    output logic [BW-1:0]     prg_bank,
    output logic              prg_rom_ce,
    output logic              prg_ram_ce,
    output logic [RAM_AW-1:0] prg_ram_addr,
    output logic              ciram_a10,
    output logic              ee_do,
    output logic              ee_clk,
    output logic              ee_cs1,
    output logic              ee_cs2,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_rd_hit
);
    bank_lo_t        bank_lo;
    logic [HI_W-1:0] bank_hi;
    ser_t            ser;
    logic            mir_vert;

    cart_regfile #(.DW(8), .HI_W(HI_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (cpu_wr),
        .page     (cpu_addr[15:8]),
        .wdata    (cpu_wdata),
        .bank_lo  (bank_lo),
        .bank_hi  (bank_hi),
        .ser      (ser),
        .mir_vert (mir_vert)
    );

    cart_prg_map #(.HI_W(HI_W)) u_map (
        .bank_lo  (bank_lo),
        .bank_hi  (bank_hi),
        .cpu_a14  (cpu_addr[14]),
        .prg_bank (prg_bank)
    );

    cart_mirror u_mir (
        .wide_mode (bank_lo.wide),
        .mir_vert  (mir_vert),
        .ppu_a10   (ppu_a10),
        .ppu_a11   (ppu_a11),
        .ciram_a10 (ciram_a10)
    );

    assign ee_do  = ser.sdo;
    assign ee_clk = ser.sclk;
    assign ee_cs1 = ser.cs1;
    assign ee_cs2 = ser.cs2;

    assign prg_ram_ce   = (cpu_addr[15:13] == 3'b011);
    assign prg_ram_addr = cpu_addr[RAM_AW-1:0];
    assign prg_rom_ce   = cpu_rd && cpu_addr[15];

    assign cpu_rd_hit = cpu_rd && (cpu_addr[15:8] == PAGE_RDS);
    assign cpu_rdata  = cpu_rd_hit ? {5'b0, ~ee_di, 2'b0} : 8'h00;
endmodule

// File: rtl/cart_prg_ctrl_chk.sv
module cart_prg_ctrl_chk #(
    parameter int RAM_AW = 11,
    parameter int HI_W   = 2,
    localparam int BW    = 5 + HI_W
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic              ee_di,
    input logic [BW-1:0]     prg_bank,
    input logic              prg_rom_ce,
    input logic              prg_ram_ce,
    input logic              ee_do,
    input logic              ee_clk,
    input logic              ee_cs1,
    input logic              ee_cs2,
    input logic [7:0]        cpu_rdata,
    input logic              cpu_rd_hit
);
    logic ser_wr, hi_wr;
    assign ser_wr = cpu_wr && (cpu_addr[15:8] == 8'h52);
    assign hi_wr  = cpu_wr && (cpu_addr[15:8] == 8'h51);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !ee_do && !ee_clk && !ee_cs1 && !ee_cs2);

    p_hi_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !hi_wr |=> $stable(prg_bank[BW-1:5]));

    p_ser_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !ser_wr |=> $stable({ee_do, ee_clk, ee_cs1, ee_cs2}));

    p_ser_load_r9: assert property (@(posedge clk) disable iff (rst)
        ser_wr |=> (ee_do == $past(cpu_wdata[0])) && (ee_cs2 == $past(cpu_wdata[6])));

    p_rd_data_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_rd_hit |-> cpu_rdata == {5'b0, !ee_di, 2'b0});

    p_rd_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd_hit |-> cpu_rdata == 8'h00);

    p_ce_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(prg_ram_ce && prg_rom_ce));

    p_rom_read_r12: assert property (@(posedge clk) disable iff (rst)
        prg_rom_ce |-> cpu_rd);
endmodule

bind cart_prg_ctrl cart_prg_ctrl_chk #(.RAM_AW(RAM_AW), .HI_W(HI_W)) u_chk (.*);

// File: tb/cart_prg_ctrl_test.sv
module cart_prg_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic        ppu_a10 = 1'b0;
    logic        ppu_a11 = 1'b0;
    logic        ee_di = 1'b0;
    logic [6:0]  prg_bank;
    logic        prg_rom_ce, prg_ram_ce, ciram_a10;
    logic [10:0] prg_ram_addr;
    logic        ee_do, ee_clk, ee_cs1, ee_cs2, cpu_rd_hit;
    logic [7:0]  cpu_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    cart_prg_ctrl uut (.*);

    // {bank_lo, bank_hi, cpu_a14, expected A20..A14}
    localparam logic [23:0] VEC [10] = '{
        {8'h00, 8'h00, 1'b0, 7'h00},   // R3
        {8'h2A, 8'h02, 1'b0, 7'h5A},   // R3 R7
        {8'h2A, 8'h01, 1'b1, 7'h3F},   // R4
        {8'h41, 8'h00, 1'b1, 7'h1E},   // R5
        {8'h40, 8'h03, 1'b1, 7'h7C},   // R5
        {8'h1B, 8'h00, 1'b0, 7'h16},   // R6
        {8'h1B, 8'h02, 1'b1, 7'h57},   // R6
        {8'h75, 8'h01, 1'b1, 7'h2B},   // R6
        {8'hF5, 8'h00, 1'b0, 7'h0A},   // R6
        {8'h60, 8'h00, 1'b0, 7'h10}    // R3
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic look(input logic [15:0] a, input logic rd);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        ppu_a10 = 1'b1; ppu_a11 = 1'b0;
        look(16'hC000, 1'b1);
        check("R1 bank", {9'b0, prg_bank}, 16'h001F);
        check("R1 mirror", {15'b0, ciram_a10}, 16'h0001);
        check("R1 serial", {12'b0, ee_cs2, ee_cs1, ee_clk, ee_do}, 16'h0000);

        // table of banking vectors
        for (int i = 0; i < 10; i++) begin
            wr(16'h5000, VEC[i][23:16]);
            wr(16'h5100, VEC[i][15:8]);
            look(VEC[i][7] ? 16'hC123 : 16'h8123, 1'b1);
            check("R3-R7 vector", {9'b0, prg_bank}, {9'b0, VEC[i][6:0]});
        end

        // R2: other pages ignored
        wr(16'h5000, 8'h1B); wr(16'h5100, 8'h02);
        wr(16'h5400, 8'hFF); wr(16'h4F00, 8'hFF); wr(16'h8000, 8'hFF);
        wr(16'h5600, 8'hFF); wr(16'h5053, 8'h1B);
        look(16'hC000, 1'b1);
        check("R2 bank unchanged", {9'b0, prg_bank}, 16'h0057);
        check("R2 serial unchanged", {12'b0, ee_cs2, ee_cs1, ee_clk, ee_do}, 16'h0000);

        // R9 serial port
        wr(16'h52FF, 8'h53);
        look(16'h0000, 1'b0);
        check("R9 all set", {12'b0, ee_cs2, ee_cs1, ee_clk, ee_do}, 16'h000F);
        wr(16'h5200, 8'h10);
        look(16'h0000, 1'b0);
        check("R9 cs1 only", {12'b0, ee_cs2, ee_cs1, ee_clk, ee_do}, 16'h0004);
        wr(16'h5200, 8'hAC);
        look(16'h0000, 1'b0);
        check("R9 unused bits", {12'b0, ee_cs2, ee_cs1, ee_clk, ee_do}, 16'h0000);

        // R8 mirroring, with simultaneous mode change
        wr(16'h5300, 8'h00);
        wr(16'h5000, 8'h03); wr(16'h5100, 8'h00);
        ppu_a10 = 1'b0; ppu_a11 = 1'b1;
        look(16'hC000, 1'b1);
        check("R8 forced vertical", {15'b0, ciram_a10}, 16'h0000);
        wr(16'h5000, 8'h13);
        look(16'hC000, 1'b1);
        check("R8 horizontal same edge", {15'b0, ciram_a10}, 16'h0001);
        check("R6 bank same edge", {9'b0, prg_bank}, 16'h0007);
        wr(16'h5300, 8'h80);
        look(16'h0000, 1'b0);
        check("R8 vertical by reg", {15'b0, ciram_a10}, 16'h0000);
        wr(16'h5300, 8'h7F);
        look(16'h0000, 1'b0);
        check("R8 bit7 only", {15'b0, ciram_a10}, 16'h0001);

        // R10 serial read
        ee_di = 1'b0;
        look(16'h55AB, 1'b1);
        check("R10 di=0", {7'b0, cpu_rd_hit, cpu_rdata}, 16'h0104);
        ee_di = 1'b1;
        look(16'h5500, 1'b1);
        check("R10 di=1", {7'b0, cpu_rd_hit, cpu_rdata}, 16'h0100);
        ee_di = 1'b0;
        look(16'h5600, 1'b1);
        check("R10 other page", {7'b0, cpu_rd_hit, cpu_rdata}, 16'h0000);
        look(16'h5500, 1'b0);
        check("R10 no read", {7'b0, cpu_rd_hit, cpu_rdata}, 16'h0000);

        // R11 PRG-RAM window
        look(16'h6000, 1'b1);
        check("R11 base", {4'b0, prg_ram_ce, prg_ram_addr}, 16'h0800);
        look(16'h7FFF, 1'b1);
        check("R11 top", {4'b0, prg_ram_ce, prg_ram_addr}, 16'h0FFF);
        look(16'h6C05, 1'b0);
        check("R11 mirror", {4'b0, prg_ram_ce, prg_ram_addr}, 16'h0C05);
        look(16'h5FFF, 1'b1);
        check("R11 below", {15'b0, prg_ram_ce}, 16'h0000);
        look(16'h8000, 1'b1);
        check("R11 above", {15'b0, prg_ram_ce}, 16'h0000);

        // R12 PRG-ROM enable
        look(16'h8000, 1'b1);
        check("R12 read low", {15'b0, prg_rom_ce}, 16'h0001);
        look(16'hFFFF, 1'b1);
        check("R12 read top", {15'b0, prg_rom_ce}, 16'h0001);
        look(16'h8000, 1'b0);
        check("R12 no read", {15'b0, prg_rom_ce}, 16'h0000);
        look(16'h7FFF, 1'b1);
        check("R12 below", {15'b0, prg_rom_ce}, 16'h0000);

        // R1 again: reset clears loaded state
        wr(16'h5200, 8'h53);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        ppu_a10 = 1'b1; ppu_a11 = 1'b0;
        look(16'hC000, 1'b1);
        check("R1 re-reset bank", {9'b0, prg_bank}, 16'h001F);
        check("R1 re-reset serial", {12'b0, ee_cs2, ee_cs1, ee_clk, ee_do}, 16'h0000);
        check("R1 re-reset mirror", {15'b0, ciram_a10}, 16'h0001);

        finish_run();
    end
endmodule